// File: doc/BRIEF.md
# Real-Time Clock Update Timing and Rate Divider

This block turns a 32.768 kHz enable pulse into the timing strobes that a real-time clock needs. It keeps a 15-bit divider phase in the system clock domain. It emits a one-cycle update strobe once per second for the time-of-day counter, and a periodic strobe at a selectable rate for the interrupt logic. An update-in-progress flag gives software warning of the next update, so that it can avoid reading the time registers while they change.

Two control registers drive it, and both are reached through an index/data port. The control register holds a three-bit divider field and a four-bit rate code. The divider field either holds the divider at its mid-second preset, runs it, or halts it with its phase kept. The mode register holds a freeze bit that stops updates while software rewrites the time. Calendar counting and alarm matching belong to neighbouring blocks.

Top module: `rtc_update_ctl`

## Requirements
- R1: After reset, the control register (select 0) reads 0x60, which holds the divider preset with the rate code at 0. The mode register (select 1) reads 0x00. `uip`, `upd_stb` and `per_stb` are all low.
- R2: While control bits 6:5 are 2'b11, the divider phase is held at 16384 of 32768. No update strobe, periodic strobe or UIP occurs, even when the rate code is nonzero.
- R3: With control bits 6:4 = 3'b010 the divider advances one step per `tick_en` pulse. The first update strobe comes exactly 16384 ticks after the preset is released. Each later one comes 32768 ticks after the one before. Each strobe is one cycle wide.
- R4: `uip` is high for exactly the 8 ticks before each update and is low in the cycle of the update strobe. Control-register read bit 7 mirrors `uip`.
- R5: While mode-register bit 7 (freeze) is 1, update strobes and UIP are suppressed but the divider keeps counting. After freeze is cleared, the next update lands on the original one-second phase.
- R6: A nonzero rate code c gives a periodic strobe on each tick where the divider phase becomes a multiple of 2^(c-1) ticks. For example, code 3 repeats every 4 ticks, code 13 every 4096 ticks (8 Hz) and code 15 every 16384 ticks (2 Hz).
- R7: Rate code 0 gives no periodic strobe. Codes 1 and 2 behave as codes 8 and 9, which repeat every 128 and 256 ticks.
- R8: A rate code rewritten between strobes takes effect at once: the next strobe comes at the next phase multiple of the new period.
- R9: Setting freeze while UIP is high drops UIP in the cycle after the write, and no update follows at that boundary.
- R10: Any other divider field value (for example 3'b000) stops the divider with its phase kept. All strobes and UIP stop, and running resumes from the same phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz base rate |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write index: 0 control, 1 mode |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read index: 0 control, 1 mode |
| rd_data | output | 8 | Read data of the selected register (control bit 7 is UIP) |
| uip | output | 1 | Update-in-progress flag |
| upd_stb | output | 1 | One-cycle once-per-second update strobe |
| per_stb | output | 1 | One-cycle periodic-rate strobe |

## Verification
The hardest state to reach is freeze being set inside the eight-tick UIP window. This needs the divider phase to sit within eight ticks of the second boundary. The stimulus runs the divider from its preset until `uip` rises, which is 32760 ticks after the first update, writes freeze in that same cycle, and then carries the phase across the boundary. A reference phase kept in the bench then predicts the exact tick of the resumed update. The same reference phase also predicts where the first strobe lands after a rate code is changed mid-period.

// File: rtl/rtc_upd_pkg.sv
`timescale 1ns/1ps
package rtc_upd_pkg;
    localparam int FIELD_W = 3;
    localparam int RATE_W  = 4;

    typedef enum logic [1:0] {
        DIV_PRESET = 2'd0,
        DIV_RUN    = 2'd1,
        DIV_HALT   = 2'd2
    } div_mode_e;

    function automatic div_mode_e decode_div(input logic [FIELD_W-1:0] field);
        if (field[2:1] == 2'b11)   return DIV_PRESET;
        else if (field == 3'b010)  return DIV_RUN;
        else                       return DIV_HALT;
    endfunction
endpackage

// File: rtl/rtc_ctl_regs.sv
`timescale 1ns/1ps
module rtc_ctl_regs
    import rtc_upd_pkg::*;
#(
    parameter logic [6:0] CTL_RESET = 7'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              rd_sel,
    input  logic              uip,
    output logic [FIELD_W-1:0] div_field,
    output logic [RATE_W-1:0]  rate_code,
    output logic              freeze,
    output logic [7:0]        rd_data
);
    typedef struct packed {
        logic [6:0] ctl;
        logic       frz;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_sel) regs_d.frz = wr_data[7];
            else        regs_d.ctl = wr_data[6:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctl <= CTL_RESET;
            regs_q.frz <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign div_field = regs_q.ctl[6:4];
    assign rate_code = regs_q.ctl[3:0];
    assign freeze    = regs_q.frz;
    assign rd_data   = rd_sel ? {regs_q.frz, 7'b0} : {uip, regs_q.ctl};
endmodule

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider
    import rtc_upd_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int UIP_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  div_mode_e        mode,
    input  logic             freeze,
    output logic [DIV_W-1:0] phase_nxt,
    output logic             adv,
    output logic             upd_stb,
    output logic             uip
);
    localparam logic [DIV_W-1:0] PH_MAX    = '1;
    localparam logic [DIV_W-1:0] PH_HALF   = {1'b1, {(DIV_W-1){1'b0}}};
    localparam logic [DIV_W-1:0] UIP_START = PH_MAX - DIV_W'(UIP_TICKS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             upd;
    } div_t;

    div_t div_d, div_q;

    assign adv       = tick_en && (mode == DIV_RUN);
    assign phase_nxt = div_q.cnt + 1'b1;

    always_comb begin
        div_d     = div_q;
        div_d.upd = 1'b0;
        unique case (mode)
            DIV_PRESET: div_d.cnt = PH_HALF;
            DIV_RUN: begin
                if (tick_en) begin
                    div_d.cnt = phase_nxt;
                    div_d.upd = (div_q.cnt == PH_MAX) && !freeze;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt <= PH_HALF;
            div_q.upd <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign upd_stb = div_q.upd;
    assign uip     = (mode == DIV_RUN) && !freeze && (div_q.cnt >= UIP_START);

    p_preset_no_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DIV_PRESET) |=> (!upd_stb && div_q.cnt == PH_HALF));
    p_strobe_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);
    p_uip_before_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |-> ($past(uip) && !uip));
    p_freeze_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !upd_stb);
endmodule

// File: rtl/rtc_periodic.sv
`timescale 1ns/1ps
module rtc_periodic
    import rtc_upd_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [DIV_W-1:0]  phase_nxt,
    input  logic [RATE_W-1:0] rate_code,
    output logic              per_stb
);
    localparam logic [RATE_W-1:0] ALIAS_ADD = RATE_W'(7);

    typedef struct packed {
        logic stb;
    } per_t;

    per_t per_d, per_q;
    logic [RATE_W-1:0] eff_code;
    logic [RATE_W-1:0] shift;
    logic [DIV_W-1:0]  mask;

    always_comb begin
        if (rate_code == RATE_W'(1) || rate_code == RATE_W'(2))
            eff_code = rate_code + ALIAS_ADD;
        else
            eff_code = rate_code;
        shift = eff_code - 1'b1;
    end

    for (genvar g = 0; g < DIV_W; g++) begin : g_mask
        assign mask[g] = (int'(shift) > g);
    end

    always_comb begin
        per_d.stb = adv && (rate_code != '0) && ((phase_nxt & mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else        per_q <= per_d;
    end

    assign per_stb = per_q.stb;

    p_needs_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb |-> $past(adv));
    p_code_zero_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == '0) |=> !per_stb);
endmodule

// File: rtl/rtc_update_ctl.sv
`timescale 1ns/1ps
module rtc_update_ctl
    import rtc_upd_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int UIP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       uip,
    output logic       upd_stb,
    output logic       per_stb
);
    logic [FIELD_W-1:0] div_field;
    logic [RATE_W-1:0]  rate_code;
    logic               freeze;
    div_mode_e          mode;
    logic [DIV_W-1:0]   phase_nxt;
    logic               adv;

    rtc_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .uip       (uip),
        .div_field (div_field),
        .rate_code (rate_code),
        .freeze    (freeze),
        .rd_data   (rd_data)
    );

    always_comb mode = decode_div(div_field);

    rtc_divider #(.DIV_W(DIV_W), .UIP_TICKS(UIP_TICKS)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .mode      (mode),
        .freeze    (freeze),
        .phase_nxt (phase_nxt),
        .adv       (adv),
        .upd_stb   (upd_stb),
        .uip       (uip)
    );

    rtc_periodic #(.DIV_W(DIV_W)) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .phase_nxt (phase_nxt),
        .rate_code (rate_code),
        .per_stb   (per_stb)
    );
endmodule

// File: tb/tb_rtc_update_ctl.sv
`timescale 1ns/1ps
module tb_rtc_update_ctl;
    logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       uip, upd_stb, per_stb;

    rtc_update_ctl dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .uip(uip), .upd_stb(upd_stb), .per_stb(per_stb)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    int ph = 16384;
    logic [6:0] m_ctl = 7'h60;
    bit m_frz = 1'b0;
    int n_upd = 0, n_per = 0, n_uipc = 0;
    bit finished = 1'b0;

    function automatic int period_of(input int c);
        int e = (c == 1) ? 8 : (c == 2) ? 9 : c;
        return 1 << (e - 1);
    endfunction
    function automatic bit m_run();
        return m_ctl[6:4] == 3'b010;
    endfunction
    function automatic bit m_pre();
        return m_ctl[6:5] == 2'b11;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit tk, input bit we = 1'b0, input bit sel = 1'b0,
                       input logic [7:0] d = 8'h00);
        bit eu, ep, eui;
        tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        eu = 1'b0; ep = 1'b0;
        if (m_pre()) ph = 16384;
        else if (m_run() && tk) begin
            ph = (ph + 1) % 32768;
            eu = (ph == 0) && !m_frz;
            ep = (m_ctl[3:0] != 0) && (ph % period_of(int'(m_ctl[3:0])) == 0);
        end
        if (we) begin
            if (sel) m_frz = d[7];
            else     m_ctl = d[6:0];
        end
        eui = m_run() && !m_frz && (ph >= 32760);
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        if (upd_stb) n_upd++;
        if (per_stb) n_per++;
        if (uip) n_uipc++;
        check("R3 update strobe timing", int'(upd_stb), int'(eu));
        check("R6 periodic strobe timing", int'(per_stb), int'(ep));
        check("R4 uip level", int'(uip), int'(eui));
    endtask

    function automatic bit pick_tick(input int dens);
        return (dens >= 8) ? 1'b1 : (($urandom % 8) < dens);
    endfunction

    task automatic run_ticks(input int n, input int dens);
        int got = 0;
        while (got < n) begin
            bit tk = pick_tick(dens);
            cyc(tk);
            if (tk) got++;
        end
    endtask

    task automatic wait_upd(input int dens, output int ticks);
        ticks = 0;
        for (int i = 0; i < 80000; i++) begin
            bit tk = pick_tick(dens);
            cyc(tk);
            if (tk) ticks++;
            if (upd_stb) break;
        end
    endtask

    task automatic wait_per(output int ticks);
        ticks = 0;
        for (int i = 0; i < 40000; i++) begin
            cyc(1'b1);
            ticks++;
            if (per_stb) break;
        end
    endtask

    task automatic wait_uip(output int ticks);
        ticks = 0;
        for (int i = 0; i < 40000; i++) begin
            cyc(1'b1);
            ticks++;
            if (uip) break;
        end
    endtask

    task automatic rd(input bit sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int t, exp;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); check("R1 control reset value", v, 8'h60);
        rd(1'b1, v); check("R1 mode reset value", v, 8'h00);
        check("R1 uip after reset", uip, 0);
        check("R1 update strobe after reset", upd_stb, 0);
        check("R1 periodic strobe after reset", per_stb, 0);

        // R2 preset holds everything, even with a rate code set
        cyc(1'b0, 1'b1, 1'b0, 8'h6D);
        n_upd = 0; n_per = 0; n_uipc = 0;
        run_ticks(2000, 8);
        check("R2 no update in preset", n_upd, 0);
        check("R2 no periodic in preset", n_per, 0);
        check("R2 no uip in preset", n_uipc, 0);

        // R3 release: first update half a second later, random tick spacing
        cyc(1'b0, 1'b1, 1'b0, 8'h20);
        wait_upd(7, t);
        check("R3 first update after release", t, 16384);

        // R4 uip rises 8 ticks before the next boundary
        wait_uip(t);
        check("R4 uip rise after update", t, 32760);
        rd(1'b0, v); check("R4 control bit7 mirrors uip", v, 8'hA0);

        // R9 freeze inside the uip window
        cyc(1'b0, 1'b1, 1'b1, 8'h80);
        check("R9 uip drops on freeze", uip, 0);
        n_upd = 0; n_uipc = 0;
        run_ticks(1000, 8);
        check("R5 R9 no update while frozen", n_upd, 0);
        check("R5 no uip while frozen", n_uipc, 0);
        rd(1'b1, v); check("R5 freeze readback", v, 8'h80);

        // R5 release: phase kept; R4 window length
        cyc(1'b0, 1'b1, 1'b1, 8'h00);
        n_uipc = 0;
        wait_upd(8, t);
        check("R5 update on kept phase", t, 32768 - 992);
        check("R4 uip window length", n_uipc, 8);
        check("R4 uip low at update", uip, 0);

        // R6 code 3
        cyc(1'b0, 1'b1, 1'b0, 8'h23);
        wait_per(t); wait_per(t);
        check("R6 code 3 period", t, 4);
        // R7 aliases
        cyc(1'b0, 1'b1, 1'b0, 8'h21);
        wait_per(t); wait_per(t);
        check("R7 code 1 aliases to 128", t, 128);
        cyc(1'b0, 1'b1, 1'b0, 8'h22);
        wait_per(t); wait_per(t);
        check("R7 code 2 aliases to 256", t, 256);
        // R6 8 Hz
        cyc(1'b0, 1'b1, 1'b0, 8'h2D);
        wait_per(t); wait_per(t);
        check("R6 code 13 period", t, 4096);
        // R8 switch to 2 Hz right after an 8 Hz strobe
        cyc(1'b0, 1'b1, 1'b0, 8'h2F);
        exp = 16384 - (ph % 16384);
        wait_per(t);
        check("R8 first 2 Hz strobe after rewrite", t, exp);
        wait_per(t);
        check("R6 code 15 period", t, 16384);
        cyc(1'b0, 1'b1, 1'b0, 8'h2D);
        wait_per(t);
        check("R8 back to 8 Hz after rewrite", t, 4096);
        // R7 code 0
        cyc(1'b0, 1'b1, 1'b0, 8'h20);
        n_per = 0;
        run_ticks(2000, 8);
        check("R7 code 0 silent", n_per, 0);
        // R10 halt keeps phase
        cyc(1'b0, 1'b1, 1'b0, 8'h03);
        n_per = 0; n_upd = 0;
        run_ticks(200, 8);
        check("R10 no periodic when halted", n_per, 0);
        check("R10 no update when halted", n_upd, 0);
        cyc(1'b0, 1'b1, 1'b0, 8'h23);
        exp = 4 - (ph % 4);
        wait_per(t);
        check("R10 resume from kept phase", t, exp);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule